// File: doc/BRIEF.md
# Sv32 Two-Level Address Translator

This unit turns a 32-bit virtual data address into a 34-bit physical address under the Sv32 paging scheme. A one-cycle start strobe samples the virtual address, the translation control word and the current privilege level. The unit then walks the two-level page table through a simple one-word memory port. Each read is a single-cycle request, and the unit waits for a response strobe carrying the data. When the walk ends, the unit pulses done for one cycle and presents the physical address together with both page-table entries it fetched. Any entry it did not fetch reads as zero.

Machine mode, or a control word whose mode bit is clear, skips the walk altogether. In that case the virtual address is passed through unchanged, no memory read is issued, and done follows the start strobe by one cycle. Permission checks beyond the leaf/invalid test are outside this unit. So are caching of translations, updates to accessed and dirty bits, and fences.

Top module: `sv32_walker`

## Requirements
- R1: While reset is held and after its release, done and mem_req are 0, and paddr, pte_hi and pte_lo are all zero.
- R2: If priv is 2'b11 (machine mode) when start is accepted, done is high in the cycle after start. In that result, paddr equals {2'b00, vaddr}, pte_hi and pte_lo are zero, and no memory read is issued.
- R3: If satp bit 31 (the mode bit) is 0 when start is accepted, the bypass behaviour of R2 applies, whatever the privilege level.
- R4: With translation enabled, the first read address is {satp[21:0], vaddr[31:22], 2'b00}.
- R5: A first-level entry counts as final when bit 0 (valid) is clear, bit 1 (read) is set, or bit 3 (execute) is set. A final first-level entry ends the walk after one read, with pte_lo zero and paddr equal to {22'b0, vaddr[11:0]}.
- R6: Any other first-level entry causes a second read at {pte1[31:10], vaddr[21:12], 2'b00}.
- R7: After a two-level walk, paddr is {pte0[31:10], vaddr[11:0]}, pte_hi holds the first entry read and pte_lo holds the second.
- R8: done is high for exactly one cycle per walk. paddr, pte_hi and pte_lo hold their values after done until the next accepted start.
- R9: mem_req is high for exactly one cycle per read. A start strobe that arrives while a walk is in progress is ignored.
- R10: vaddr, satp and priv are sampled only in the cycle start is accepted. Later changes to them do not affect the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a translation (accepted when idle) |
| vaddr | input | 32 | Virtual address |
| satp | input | 32 | Translation control word: bit 31 mode, bits 21:0 root table number |
| priv | input | 2 | Current privilege level, 2'b11 is machine mode |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 34 | Read address, valid while mem_req is high |
| mem_rvalid | input | 1 | Read response strobe |
| mem_rdata | input | 32 | Read response data |
| paddr | output | 34 | Translated physical address |
| pte_hi | output | 32 | First-level entry used, zero if not read |
| pte_lo | output | 32 | Second-level entry used, zero if not read |
| done | output | 1 | One-cycle completion pulse |

## Verification
The translation path is driven with a set of distinct inputs:
- machine-mode and bare-mode bypasses, which separate the two skip conditions from each other and from a real walk;
- first-level entries that end the walk through a clear valid bit, a set read bit and a set execute bit, each of which is a separate way of stopping early;
- full two-level walks, including one where every root, index and offset bit is set, which exposes any bit that is dropped or misplaced in the address concatenations.

The reserved privilege level is used to show that only machine mode bypasses. Response latency is varied between walks. Inputs are scrambled after start to confirm they are captured. A second start arriving mid-walk confirms that it is ignored.

// File: rtl/sv32_walker.sv
`timescale 1ns/1ps
module sv32_walker #(
  parameter int VA_W = 32,
  parameter int PA_W = 34
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VA_W-1:0] vaddr,
  input  logic [31:0]     satp,
  input  logic [1:0]      priv,
  output logic            mem_req,
  output logic [PA_W-1:0] mem_addr,
  input  logic            mem_rvalid,
  input  logic [31:0]     mem_rdata,
  output logic [PA_W-1:0] paddr,
  output logic [31:0]     pte_hi,
  output logic [31:0]     pte_lo,
  output logic            done
);
  localparam int OFS_W  = 12;
  localparam int IDX_W  = 10;
  localparam int PPN_W  = PA_W - OFS_W;
  localparam int PAD_W  = PA_W - VA_W;

  typedef enum logic [2:0] {S_IDLE, S_RD1, S_WT1, S_RD0, S_WT0, S_FIN} st_t;
  st_t st;

  logic [VA_W-1:0]  va;
  logic [PPN_W-1:0] root;

  wire bypass = (priv == 2'b11) || !satp[31];
  wire final1 = !mem_rdata[0] || mem_rdata[1] || mem_rdata[3];

  assign mem_req  = (st == S_RD1) || (st == S_RD0);
  assign mem_addr = (st == S_RD1) ? {root, va[31 -: IDX_W], 2'b00}
                                  : {pte_hi[31 -: PPN_W], va[21 -: IDX_W], 2'b00};
  assign done     = (st == S_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      va     <= '0;
      root   <= '0;
      paddr  <= '0;
      pte_hi <= '0;
      pte_lo <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          va     <= vaddr;
          root   <= satp[PPN_W-1:0];
          pte_hi <= '0;
          pte_lo <= '0;
          if (bypass) begin
            paddr <= {{PAD_W{1'b0}}, vaddr};
            st    <= S_FIN;
          end else begin
            st <= S_RD1;
          end
        end
        S_RD1: st <= S_WT1;
        S_WT1: if (mem_rvalid) begin
          pte_hi <= mem_rdata;
          if (final1) begin
            paddr <= {{PPN_W{1'b0}}, va[OFS_W-1:0]};
            st    <= S_FIN;
          end else begin
            st <= S_RD0;
          end
        end
        S_RD0: st <= S_WT0;
        S_WT0: if (mem_rvalid) begin
          pte_lo <= mem_rdata;
          paddr  <= {mem_rdata[31 -: PPN_W], va[OFS_W-1:0]};
          st     <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  wire idle = (st == S_IDLE);
endmodule

module sv32_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [31:0] satp,
  input logic [1:0]  priv,
  input logic        idle,
  input logic        mem_req,
  input logic        done,
  input logic [31:0] pte_hi,
  input logic [31:0] pte_lo
);
  p_bypass_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idle && start && (priv == 2'b11 || !satp[31]) |=> done)
    else $error("bypass did not finish next cycle");  // also covers R3

  p_final_l1_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && (!pte_hi[0] || pte_hi[1] || pte_hi[3]) |-> pte_lo == 32'h0)
    else $error("second entry nonzero after final first entry");

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done longer than one cycle");

  p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req)
    else $error("request longer than one cycle");

  p_req_not_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !done)
    else $error("request during done");

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !done && !mem_req)
    else $error("outputs active after reset");
endmodule

bind sv32_walker sv32_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .satp(satp), .priv(priv),
  .idle(idle), .mem_req(mem_req), .done(done), .pte_hi(pte_hi), .pte_lo(pte_lo)
);

// File: tb/tb_sv32_walker.sv
`timescale 1ns/1ps
module tb_sv32_walker;
  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] vaddr = 0, satp = 0;
  logic [1:0]  priv = 0;
  logic        mem_req, mem_rvalid = 0;
  logic [33:0] mem_addr, paddr;
  logic [31:0] mem_rdata = 0, pte_hi, pte_lo;
  logic        done;

  int errs = 0, checks = 0, cycles = 0;

  sv32_walker dut (.*);

  always #10 clk = ~clk;

  logic [31:0] g_p1, g_p0;
  int g_lat = 1, nreads = 0, pending = 0;
  logic [33:0] seen [2];

  initial begin
    forever begin
      @(negedge clk);
      if (mem_rvalid) mem_rvalid = 0;
      if (mem_req) begin
        if (nreads < 2) seen[nreads] = mem_addr;
        nreads++;
        pending = g_lat;
      end else if (pending > 0) begin
        pending--;
        if (pending == 0) begin
          mem_rvalid = 1;
          mem_rdata  = (nreads == 1) ? g_p1 : g_p0;
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errs++; checks++;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected < 100000)", cycles);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  localparam int NV = 8;
  localparam logic [31:0] T_VA [NV] = '{32'h12345678, 32'hCAFEF00D, 32'h40301ABC, 32'hFFC00FFF,
                                        32'h0F0F0F0F, 32'h87654321, 32'hFFFFFFFF, 32'h00000ABC};
  localparam logic [31:0] T_SATP [NV] = '{32'h80000001, 32'h00000005, 32'h80000123, 32'h80000077,
                                          32'h80200000, 32'h80000042, 32'hFFFFFFFF, 32'h80000010};
  localparam logic [1:0]  T_PRIV [NV] = '{2'b11, 2'b00, 2'b00, 2'b01, 2'b00, 2'b01, 2'b00, 2'b10};
  localparam logic [31:0] T_P1 [NV] = '{32'h11111111, 32'h22222222, 32'h00012001, 32'h20000003,
                                        32'hABCDE400, 32'h00001009, 32'hFFFFFC01, 32'h00000401};
  localparam logic [31:0] T_P0 [NV] = '{32'h33333333, 32'h44444444, 32'h1234500F, 32'h55555555,
                                        32'h66666666, 32'h77777777, 32'hFFFFFFFF, 32'h00000C01};

  task automatic walk(input logic [31:0] va, input logic [31:0] sp, input logic [1:0] pv,
                      input logic [31:0] p1, input logic [31:0] p0, input int lat);
    logic byp, fin1;
    logic [33:0] e1, e0, ep, hold_pa;
    int n, ereads;
    g_p1 = p1; g_p0 = p0; g_lat = lat; nreads = 0;
    seen[0] = '0; seen[1] = '0;
    @(negedge clk);
    vaddr = va; satp = sp; priv = pv; start = 1;
    @(negedge clk);
    start = 0; vaddr = ~va; satp = ~sp; priv = ~pv;  // R10: scramble after capture
    n = 1;
    while (!done && n < 60) begin @(negedge clk); n++; end
    byp  = (pv == 2'b11) || !sp[31];
    fin1 = !p1[0] || p1[1] || p1[3];
    e1 = {sp[21:0], va[31:22], 2'b00};
    e0 = {p1[31:10], va[21:12], 2'b00};
    if (byp) begin ep = {2'b00, va}; ereads = 0; end
    else if (fin1) begin ep = {22'b0, va[11:0]}; ereads = 1; end
    else begin ep = {p0[31:10], va[11:0]}; ereads = 2; end
    chk("R8 done seen", 64'(done), 64'd1);
    if (byp) begin
      chk(pv == 2'b11 ? "R2 bypass latency" : "R3 bypass latency", 64'(n), 64'd1);
      chk(pv == 2'b11 ? "R2 bypass paddr" : "R3 bypass paddr", 64'(paddr), 64'(ep));
      chk("R2 bypass pte_hi", 64'(pte_hi), 64'd0);
      chk("R3 bypass pte_lo", 64'(pte_lo), 64'd0);
    end else begin
      chk("R4 first read addr r10_", 64'(seen[0]), 64'(e1));
      chk("R7 pte_hi", 64'(pte_hi), 64'(p1));
      if (fin1) begin
        chk("R5 paddr", 64'(paddr), 64'(ep));
        chk("R5 pte_lo", 64'(pte_lo), 64'd0);
      end else begin
        chk("R6 second read addr", 64'(seen[1]), 64'(e0));
        chk("R7 paddr", 64'(paddr), 64'(ep));
        chk("R7 pte_lo", 64'(pte_lo), 64'(p0));
      end
    end
    chk("R9 read count", 64'(nreads), 64'(ereads));
    hold_pa = paddr;
    @(negedge clk);
    chk("R8 done one cycle", 64'(done), 64'd0);
    repeat (3) @(negedge clk);
    chk("R8 paddr held", 64'(paddr), 64'(hold_pa));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset done", 64'(done), 64'd0);
    chk("R1 reset req", 64'(mem_req), 64'd0);
    chk("R1 reset paddr", 64'(paddr), 64'd0);
    chk("R1 reset ptes", {pte_hi, pte_lo}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release done", 64'(done), 64'd0);

    for (int i = 0; i < NV; i++)
      walk(T_VA[i], T_SATP[i], T_PRIV[i], T_P1[i], T_P0[i], (i % 2 == 0) ? 1 : 3);

    // R9: start while busy is ignored
    g_p1 = 32'h00003001; g_p0 = 32'h0ABCD001; g_lat = 3; nreads = 0;
    @(negedge clk);
    vaddr = 32'h00402345; satp = 32'h80000009; priv = 2'b00; start = 1;
    @(negedge clk); start = 0;
    @(negedge clk);
    vaddr = 32'hDEADBEEF; priv = 2'b11; start = 1;
    @(negedge clk); start = 0;
    chk("R9 busy start no early done", 64'(done), 64'd0);
    begin
      int n = 0;
      while (!done && n < 60) begin @(negedge clk); n++; end
    end
    chk("R9 busy start walk result", 64'(paddr), 64'({20'h0ABCD >> 0, 2'b00, 12'h345} & 34'h3FFFFFFFF));
    chk("R9 busy start reads", 64'(nreads), 64'd2);
    @(negedge clk);
    chk("R9 no second done", 64'(done), 64'd0);
    repeat (4) @(negedge clk);
    chk("R9 stays idle", 64'(done | mem_req), 64'd0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule